// File: doc/BRIEF.md
# Direction-Switchable Ping-Pong Bulk Buffer

This block sits between a USB bulk endpoint and a media interface engine. Two banks of `DEPTH` bytes (512 by default) alternate roles, so one side can stream bytes without stalling. While one side fills a bank, the other side drains the bank filled before it. A single mode bit decides the direction. In transmit mode the media side fills the banks and the USB side drains them. In receive mode the USB side fills and the media side drains.

The producer writes bytes with a valid/ready handshake. It closes ("commits") a bank in either of two ways: by flagging the last byte, which gives a short bank, or by writing the bank's final slot, which commits it on its own. The consumer sees first-word-fall-through data, the byte count of the bank it is reading, and a last-byte marker.

An embedded microcontroller reaches any stored byte through a third, random-access port. That port addresses a byte as {bank, offset}. The CPU port has priority: when it touches the bank that either stream side is using in the same cycle, that stream side is held for the cycle.

Top module: `pp_bulk_buf`

## Requirements
- R1: After reset the mode is transmit (`mode`=0), `mode_err` is 0, no consumer output is valid, and the media side is ready to write while the USB side is not.
- R2: In transmit mode (`mode`=0), bytes written on the media side come out on the USB side in the order they were written.
- R3: In receive mode (`mode`=1), bytes written on the USB side come out on the media side in the order they were written.
- R4: The banks alternate, starting with bank 0 after reset. The producer fills one bank while the other is full. Its ready signal drops only when both banks are full.
- R5: Writing a byte with `*_wlast`=1 commits the bank with a count equal to the bytes written into it. The consumer's `*_rcount` shows that count, and `*_rlast` is 1 exactly on its final byte.
- R6: Writing the `DEPTH`-th byte of a bank commits it with count `DEPTH` even when `*_wlast` is 0.
- R7: A mode request is accepted only when both banks are empty and no uncommitted bytes are held. Otherwise `mode` is unchanged and `mode_err` is 1 in the cycle after the request. `mode_err` is 0 after an accepted request or after no request.
- R8: Writes on the side that is not the producer are ignored, and that side's `*_wready` is 0. The side that is not the consumer has `*_rvalid`=0 and `*_rcount`=0.
- R9: A CPU read (`cpu_en`=1, `cpu_we`=0) returns in `cpu_rdata`, one cycle later, the byte at bank `cpu_addr[AW]`, offset `cpu_addr[AW-1:0]`.
- R10: A CPU write replaces the stored byte. The consumer later reads the new value at that position.
- R11: A CPU access to the producer's current bank forces the producer's `*_wready` to 0 for that cycle. A CPU access to the consumer's current bank forces `*_rvalid` to 0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Request a direction change |
| mode_sel | input | 1 | Requested direction: 0 transmit, 1 receive |
| mode | output | 1 | Current direction |
| mode_err | output | 1 | Previous request was rejected |
| usb_wvalid | input | 1 | USB side write strobe |
| usb_wlast | input | 1 | USB write commits the bank |
| usb_wdata | input | DW | USB write byte |
| usb_wready | output | 1 | USB write accepted this cycle |
| usb_rd | input | 1 | USB side read advance |
| usb_rvalid | output | 1 | USB read byte valid |
| usb_rdata | output | DW | USB read byte |
| usb_rlast | output | 1 | Final byte of the bank |
| usb_rcount | output | AW+1 | Byte count of the bank being read |
| media_wvalid | input | 1 | Media side write strobe |
| media_wlast | input | 1 | Media write commits the bank |
| media_wdata | input | DW | Media write byte |
| media_wready | output | 1 | Media write accepted this cycle |
| media_rd | input | 1 | Media side read advance |
| media_rvalid | output | 1 | Media read byte valid |
| media_rdata | output | DW | Media read byte |
| media_rlast | output | 1 | Final byte of the bank |
| media_rcount | output | AW+1 | Byte count of the bank being read |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | AW+1 | {bank, offset} |
| cpu_wdata | input | DW | CPU write byte |
| cpu_rdata | output | DW | CPU read byte, one cycle after the access |

## Verification
Two things can land in the same cycle and compete for the same storage: a CPU access and a stream access. The bench provokes this in two ways. It holds a producer write pending while the CPU addresses the producer's open bank, and it keeps a committed bank waiting while the CPU reads from it. In each case it samples the stream handshake inside that cycle and expects it to be low, then expects it to recover on the next cycle. It then drains the bank and checks that a byte the CPU rewrote comes out with the new value while every other byte keeps its order.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic {
      MODE_TX = 1'b0,   // media produces, USB consumes
      MODE_RX = 1'b1    // USB produces, media consumes
   } xfer_mode_e;
endpackage

// File: rtl/pp_store.sv
module pp_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          s_we,
   input  logic [AW:0]   s_waddr,
   input  logic [DW-1:0] s_wdata,
   input  logic [AW:0]   s_raddr,
   output logic [DW-1:0] s_rdata,
   input  logic          c_en,
   input  logic          c_we,
   input  logic [AW:0]   c_addr,
   input  logic [DW-1:0] c_wdata,
   output logic [DW-1:0] c_rdata
);
   localparam int WORDS = 2 * DEPTH;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (s_we)
         mem[s_waddr] <= s_wdata;
      if (c_en && c_we)
         mem[c_addr] <= c_wdata;
      if (c_en && !c_we)
         c_rdata <= mem[c_addr];
   end

   assign s_rdata = mem[s_raddr];
endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fire,
   input  logic        last,
   output logic        wbank,
   output logic [AW-1:0] wptr,
   output logic        commit,
   output logic [AW:0] commit_len
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   assign commit     = fire && (last || wptr == TOP);
   assign commit_len = {1'b0, wptr} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wbank <= 1'b0;
         wptr  <= '0;
      end else if (commit) begin
         wbank <= ~wbank;
         wptr  <= '0;
      end else if (fire) begin
         wptr  <= wptr + 1'b1;
      end
   end
endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fire,
   input  logic [AW:0] len,
   output logic        rbank,
   output logic [AW-1:0] rptr,
   output logic        rlast,
   output logic        done
);
   assign rlast = ({1'b0, rptr} + 1'b1) == len;
   assign done  = fire && rlast;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbank <= 1'b0;
         rptr  <= '0;
      end else if (done) begin
         rbank <= ~rbank;
         rptr  <= '0;
      end else if (fire) begin
         rptr  <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/pp_bulk_buf.sv
module pp_bulk_buf
   import pp_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_req,
   input  logic          mode_sel,
   output logic          mode,
   output logic          mode_err,
   input  logic          usb_wvalid,
   input  logic          usb_wlast,
   input  logic [DW-1:0] usb_wdata,
   output logic          usb_wready,
   input  logic          usb_rd,
   output logic          usb_rvalid,
   output logic [DW-1:0] usb_rdata,
   output logic          usb_rlast,
   output logic [AW:0]   usb_rcount,
   input  logic          media_wvalid,
   input  logic          media_wlast,
   input  logic [DW-1:0] media_wdata,
   output logic          media_wready,
   input  logic          media_rd,
   output logic          media_rvalid,
   output logic [DW-1:0] media_rdata,
   output logic          media_rlast,
   output logic [AW:0]   media_rcount,
   input  logic          cpu_en,
   input  logic          cpu_we,
   input  logic [AW:0]   cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   xfer_mode_e mode_q;
   logic       mode_rx;
   logic [1:0] full_q;
   logic [AW:0] len_q [2];

   logic          prod_wvalid, prod_wlast, prod_wready, wr_fire;
   logic [DW-1:0] prod_wdata;
   logic          cons_rd, cons_rvalid, rd_fire;
   logic          wbank, rbank, commit, done, cons_rlast;
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   commit_len, cons_len;
   logic [DW-1:0] s_rdata;
   logic          cpu_bank, cpu_hit_w, cpu_hit_r, mode_ok;

   assign mode_rx = (mode_q == MODE_RX);
   assign mode    = mode_q;

   // role steering
   assign prod_wvalid = mode_rx ? usb_wvalid : media_wvalid;
   assign prod_wlast  = mode_rx ? usb_wlast  : media_wlast;
   assign prod_wdata  = mode_rx ? usb_wdata  : media_wdata;
   assign cons_rd     = mode_rx ? media_rd   : usb_rd;

   // CPU priority over the stream side that owns the addressed bank
   assign cpu_bank  = cpu_addr[AW];
   assign cpu_hit_w = cpu_en && (cpu_bank == wbank);
   assign cpu_hit_r = cpu_en && (cpu_bank == rbank);

   assign prod_wready = !full_q[wbank] && !cpu_hit_w;
   assign cons_rvalid = full_q[rbank] && !cpu_hit_r;
   assign wr_fire     = prod_wvalid && prod_wready;
   assign rd_fire     = cons_rd && cons_rvalid;
   assign cons_len    = len_q[rbank];

   assign usb_wready   = mode_rx  && prod_wready;
   assign media_wready = !mode_rx && prod_wready;
   assign usb_rvalid   = !mode_rx && cons_rvalid;
   assign media_rvalid = mode_rx  && cons_rvalid;
   assign usb_rdata    = s_rdata;
   assign media_rdata  = s_rdata;
   assign usb_rlast    = usb_rvalid && cons_rlast;
   assign media_rlast  = media_rvalid && cons_rlast;
   assign usb_rcount   = (!mode_rx && full_q[rbank]) ? cons_len : '0;
   assign media_rcount = (mode_rx && full_q[rbank]) ? cons_len : '0;

   pp_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
      .clk(clk), .rst_n(rst_n), .fire(wr_fire), .last(prod_wlast),
      .wbank(wbank), .wptr(wptr), .commit(commit), .commit_len(commit_len)
   );

   pp_drain_ctrl #(.DEPTH(DEPTH)) u_drain (
      .clk(clk), .rst_n(rst_n), .fire(rd_fire), .len(cons_len),
      .rbank(rbank), .rptr(rptr), .rlast(cons_rlast), .done(done)
   );

   pp_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk),
      .s_we(wr_fire), .s_waddr({wbank, wptr}), .s_wdata(prod_wdata),
      .s_raddr({rbank, rptr}), .s_rdata(s_rdata),
      .c_en(cpu_en), .c_we(cpu_we), .c_addr(cpu_addr),
      .c_wdata(cpu_wdata), .c_rdata(cpu_rdata)
   );

   // per-bank occupancy and committed length
   for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q[b] <= 1'b0;
            len_q[b]  <= '0;
         end else begin
            if (commit && wbank == 1'(b)) begin
               full_q[b] <= 1'b1;
               len_q[b]  <= commit_len;
            end else if (done && rbank == 1'(b)) begin
               full_q[b] <= 1'b0;
            end
         end
      end
   end

   // direction change only on a fully drained buffer
   assign mode_ok = (full_q == 2'b00) && (wptr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_TX;
         mode_err <= 1'b0;
      end else begin
         mode_err <= mode_req && !mode_ok;
         if (mode_req && mode_ok)
            mode_q <= xfer_mode_e'(mode_sel);
      end
   end
endmodule

// File: rtl/pp_bulk_chk.sv
module pp_bulk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_req,
   input logic       mode_ok,
   input logic       mode,
   input logic       mode_err,
   input logic       usb_wready,
   input logic       media_wready,
   input logic       usb_rvalid,
   input logic       media_rvalid,
   input logic       wr_fire,
   input logic       rd_fire,
   input logic       wbank,
   input logic       rbank,
   input logic [1:0] full_q,
   input logic       cpu_hit_w
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> !full_q[wbank]);                                   // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |-> full_q[rbank]);                                    // R2
   AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req && !mode_ok) |=> mode_err);                          // R7
   AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req && !mode_ok) |=> $stable(mode));                     // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_req |=> ($stable(mode) && !mode_err));                   // R7
   AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit_w |-> !wr_fire);                                       // R11
   AST_ONE_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      !(usb_wready && media_wready));                                // R8
   AST_ONE_CONSUMER: assert property (@(posedge clk) disable iff (!rst_n)
      !(usb_rvalid && media_rvalid));                                // R8
endmodule

bind pp_bulk_buf pp_bulk_chk u_chk (.*);

// File: tb/sim_pp_bulk_buf.sv
module sim_pp_bulk_buf;
   localparam int DW = 8;
   localparam int DEPTH = 512;
   localparam int AW = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode_req = 0, mode_sel = 0, mode, mode_err;
   logic usb_wvalid = 0, usb_wlast = 0, usb_wready, usb_rd = 0;
   logic [DW-1:0] usb_wdata = '0, usb_rdata;
   logic usb_rvalid, usb_rlast;
   logic [AW:0] usb_rcount;
   logic media_wvalid = 0, media_wlast = 0, media_wready, media_rd = 0;
   logic [DW-1:0] media_wdata = '0, media_rdata;
   logic media_rvalid, media_rlast;
   logic [AW:0] media_rcount;
   logic cpu_en = 0, cpu_we = 0;
   logic [AW:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] exp_q [$];
   int prod_commits = 0;
   int fill_cnt = 0;

   always #4 clk = ~clk;

   pp_bulk_buf #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: writes one byte on the chosen side, pushes it to the scoreboard
   task automatic put(input bit usb, input logic [DW-1:0] d, input bit last);
      forever begin
         @(negedge clk);
         if (usb) begin usb_wvalid = 1; usb_wdata = d; usb_wlast = last; end
         else begin media_wvalid = 1; media_wdata = d; media_wlast = last; end
         #1;
         if (usb ? usb_wready : media_wready) break;
      end
      @(posedge clk);
      #1;
      usb_wvalid = 0; media_wvalid = 0; usb_wlast = 0; media_wlast = 0;
      exp_q.push_back(d);
      fill_cnt++;
      if (last || fill_cnt == DEPTH) begin
         prod_commits++;
         fill_cnt = 0;
      end
   endtask

   // monitor: reads one byte on the chosen side and compares with the scoreboard
   task automatic take(input bit usb, input string req, input int cnt, input bit exp_last);
      logic [DW-1:0] got, want;
      logic lst;
      logic [AW:0] rc;
      forever begin
         @(negedge clk);
         #1;
         if (usb ? usb_rvalid : media_rvalid) break;
      end
      got = usb ? usb_rdata : media_rdata;
      lst = usb ? usb_rlast : media_rlast;
      rc  = usb ? usb_rcount : media_rcount;
      if (usb) usb_rd = 1; else media_rd = 1;
      @(posedge clk);
      #1;
      usb_rd = 0; media_rd = 0;
      want = exp_q.pop_front();
      chk(got == want, req, got, want);
      if (cnt > 0) begin
         chk(rc == cnt, "R5 rcount", rc, cnt);
         chk(lst == exp_last, "R5 rlast", lst, exp_last);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      int b;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(mode == 0, "R1 mode", mode, 0);
      chk(mode_err == 0, "R1 mode_err", mode_err, 0);
      chk(usb_rvalid == 0 && media_rvalid == 0, "R1 rvalid", usb_rvalid, 0);
      chk(media_wready == 1 && usb_wready == 0, "R1 wready", media_wready, 1);

      // R2/R5 short bank in transmit mode
      for (int i = 0; i < 5; i++) put(0, 8'(8'h10 + i), i == 4);
      for (int i = 0; i < 5; i++) take(1, "R2 data", 5, i == 4);

      // R6 auto commit and R4 alternation / stall only when both full
      for (int i = 0; i < DEPTH; i++) put(0, 8'(i * 3), 0);
      @(negedge clk); #1;
      chk(media_wready == 1, "R4 second bank free", media_wready, 1);
      chk(usb_rcount == DEPTH, "R6 rcount", usb_rcount, DEPTH);
      for (int i = 0; i < DEPTH; i++) put(0, 8'(i * 5 + 1), 0);
      @(negedge clk); #1;
      chk(media_wready == 0, "R4 stall both full", media_wready, 0);
      for (int i = 0; i < 2 * DEPTH; i++)
         take(1, "R6 data", (i % DEPTH == DEPTH - 1) ? DEPTH : 0, 1);

      // R7 rejected request
      for (int i = 0; i < 3; i++) put(0, 8'(8'h70 + i), i == 2);
      @(negedge clk); mode_req = 1; mode_sel = 1;
      @(posedge clk); #1 mode_req = 0;
      chk(mode_err == 1, "R7 err raised", mode_err, 1);
      chk(mode == 0, "R7 mode kept", mode, 0);
      @(posedge clk); #1;
      chk(mode_err == 0, "R7 err cleared", mode_err, 0);
      for (int i = 0; i < 3; i++) take(1, "R7 data", 3, i == 2);
      // R7 rejected with uncommitted bytes
      put(0, 8'h55, 0);
      @(negedge clk); mode_req = 1; mode_sel = 1;
      @(posedge clk); #1 mode_req = 0;
      chk(mode_err == 1 && mode == 0, "R7 partial reject", mode, 0);
      put(0, 8'h56, 1);
      take(1, "R7 data", 2, 0);
      take(1, "R7 data", 2, 1);
      // R7 accepted
      @(negedge clk); mode_req = 1; mode_sel = 1;
      @(posedge clk); #1 mode_req = 0;
      chk(mode == 1 && mode_err == 0, "R7 accept", mode, 1);
      chk(usb_wready == 1 && media_wready == 0, "R3 roles", usb_wready, 1);

      // R8 media writes ignored in receive mode
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); media_wvalid = 1; media_wdata = 8'hEE; media_wlast = 1;
         #1 chk(media_wready == 0, "R8 media wready", media_wready, 0);
      end
      @(negedge clk); media_wvalid = 0; media_wlast = 0;
      #1 chk(media_rvalid == 0, "R8 nothing stored", media_rvalid, 0);
      for (int i = 0; i < 4; i++) put(1, 8'(8'hA0 + i), i == 3);
      @(negedge clk); #1;
      chk(usb_rvalid == 0 && usb_rcount == 0, "R8 usb not consumer", usb_rcount, 0);
      for (int i = 0; i < 4; i++) take(0, "R3 data", 4, i == 3);

      // R4 concurrent streaming in receive mode
      fork
         for (int i = 0; i < 700; i++) put(1, 8'(i * 7 + 2), (i % 300) == 299 || i == 699);
         for (int i = 0; i < 700; i++) take(0, "R4 concurrent data", 0, 0);
      join

      // R9/R10/R11 CPU port
      b = prod_commits % 2;
      for (int i = 0; i < 6; i++) put(1, 8'(8'hC0 + i), i == 5);
      @(negedge clk); cpu_en = 1; cpu_we = 0; cpu_addr = {1'(b), AW'(1)};
      #1 chk(media_rvalid == 0, "R11 consumer held", media_rvalid, 0);
      @(posedge clk); #1 cpu_en = 0;
      chk(cpu_rdata == exp_q[1], "R9 cpu read", cpu_rdata, exp_q[1]);
      @(negedge clk); #1;
      chk(media_rvalid == 1, "R11 consumer resumes", media_rvalid, 1);
      @(negedge clk); cpu_en = 1; cpu_we = 1; cpu_addr = {1'(b), AW'(2)}; cpu_wdata = 8'hA5;
      @(posedge clk); #1 cpu_en = 0; cpu_we = 0;
      exp_q[2] = 8'hA5;
      @(negedge clk); cpu_en = 1; cpu_addr = {1'(1 - b), AW'(0)};
      usb_wvalid = 1; usb_wdata = 8'h99; usb_wlast = 1;
      #1 chk(usb_wready == 0, "R11 producer held", usb_wready, 0);
      @(posedge clk); #1 cpu_en = 0; usb_wvalid = 0; usb_wlast = 0;
      for (int i = 0; i < 6; i++) take(0, "R10 data after cpu write", 6, i == 5);
      @(negedge clk); #1;
      chk(media_rvalid == 0, "R11 held write not stored", media_rvalid, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule